// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block is the digital timing core of a converter model. It runs from the master clock and stays in a fixed wake-up period after reset. It then accepts active-low conversion requests and times each conversion by counting master clock cycles. At the end of each conversion it drives its active-low ready flag low and loads a fresh result. The request pin may be held low for back-to-back conversions, wired to the ready output, or pulsed from logic that does not share the master clock. Each of these gives its own fixed cadence, because the request passes through a two-flop synchronizer before the control logic sees it.

The result comes from a stub data source: either a raw input bus or, when a parameter selects it, an internal conversion counter. The raw value is treated as an offset-binary code. The bipolar/unipolar select travels through the same synchronizer as the request. The control logic latches it when a conversion starts, so the mode that counts is the one present at the first clock edge that sees the request low. The block is meant to feed a serial output port, which reads the result while ready is low.

Top module: `adc_conv_seq`

## Requirements
- R1: While rst_ni is low, rdy_no is high and result_o is 0.
- R2: After rst_ni rises, rdy_no first falls on exactly the 1536th rising clock edge. Requests made during this wake-up period are ignored: no conversion follows them and result_o stays 0.
- R3: A conversion raises rdy_no on its start edge and drops it exactly 79 rising edges later. rdy_no stays low for at least one cycle between conversions.
- R4: With conv_ni held low, rdy_no falls every 80 clocks. After conv_ni is released, at most the one conversion already committed still completes.
- R5: With conv_ni wired to rdy_no, rdy_no falls every 82 clocks. Unwiring it, and driving conv_ni high half a cycle after a fall, leaves no conversion pending.
- R6: For a single request, rdy_no falls on the 81st rising edge after the first edge that samples conv_ni low. That is at most 82 clocks after the request edge, which is within the 84-clock bound.
- R7: A low pulse of 4 clocks on conv_ni starts exactly one conversion. Request activity while a conversion is running starts no further conversion.
- R8: The bipolar_i value sampled at the first edge that sees conv_ni low sets the format for that conversion. Later changes to bipolar_i have no effect on it.
- R9: raw_i is sampled on the edge where rdy_no falls. In unipolar mode (bipolar_i=0) result_o equals raw_i. In bipolar mode (bipolar_i=1) result_o equals raw_i with its MSB inverted, which is two's complement of the offset-binary code.
- R10: result_o changes only on an edge where rdy_no falls and holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| conv_ni | input | 1 | Active-low conversion request, may be asynchronous |
| bipolar_i | input | 1 | 1 = bipolar (two's complement), 0 = unipolar (offset binary) |
| raw_i | input | 16 | Stub raw sample, offset-binary code |
| rdy_no | output | 1 | Active-low ready, falls when a new result is loaded |
| result_o | output | 16 | Formatted conversion result |

## Verification
Every timing result is counted from a rising-edge counter kept in the bench. A request driven on the falling edge before edge A is due to lower ready at edge A+81. Held-low requests give ready falls 80 edges apart, and a request wired to ready gives falls 82 edges apart. The first fall after reset is due on the 1536th edge. The bench samples ready and the result on the falling edge that follows the expected rising edge, and it compares the recorded edge number with these exact values. The bench also checks that ready rises at A+2 and is still low at A+1. Mode changes and raw data changes are placed in specific cycles relative to edge A and to the fall, which shows which sample the block takes.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_WAKE = 2'd0,
    ST_IDLE = 2'd1,
    ST_BUSY = 2'd2
  } seq_state_e;
endpackage

// File: rtl/adc_req_sync.sv
// Synchronizes the request and carries the mode select alongside it,
// so the mode seen at start matches the first edge sampling the request.
module adc_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic conv_ni,
  input  logic bipolar_i,
  output logic req_low_o,
  output logic mode_o
);
  logic [STAGES-1:0] req_q;
  logic [STAGES-1:0] mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= '1;
      mode_q <= '0;
    end else begin
      req_q  <= {req_q[STAGES-2:0], conv_ni};
      mode_q <= {mode_q[STAGES-2:0], bipolar_i};
    end
  end

  assign req_low_o = ~req_q[STAGES-1];
  assign mode_o    = mode_q[STAGES-1];
endmodule

// File: rtl/adc_wake_timer.sv
module adc_wake_timer #(
  parameter int WAKE_CYCLES = 1536
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic done_o
);
  localparam int CNT_W = $clog2(WAKE_CYCLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WAKE_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             awake_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      awake_q <= 1'b0;
    end else if (!awake_q) begin
      if (cnt_q == LAST) awake_q <= 1'b1;
      else               cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign done_o = !awake_q && (cnt_q == LAST);
endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CONV_LEN = 79
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wake_done_i,
  input  logic req_low_i,
  input  logic mode_i,
  output logic rdy_no,
  output logic done_o,
  output logic mode_q_o
);
  localparam int CNT_W = $clog2(CONV_LEN);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_LEN - 1);

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             mode_q;

  assign done_o = (state_q == ST_BUSY) && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_WAKE;
      cnt_q   <= '0;
      mode_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_WAKE: if (wake_done_i) state_q <= ST_IDLE;
        ST_IDLE: if (req_low_i) begin
          state_q <= ST_BUSY;
          cnt_q   <= '0;
          mode_q  <= mode_i;
        end
        ST_BUSY: begin
          if (done_o) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_WAKE;
      endcase
    end
  end

  // ready is low only while waiting for a request after a result
  assign rdy_no   = (state_q != ST_IDLE);
  assign mode_q_o = mode_q;
endmodule

// File: rtl/adc_result_fmt.sv
module adc_result_fmt #(
  parameter int DATA_W      = 16,
  parameter bit SRC_COUNTER = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              bipolar_i,
  input  logic [DATA_W-1:0] raw_i,
  output logic [DATA_W-1:0] result_o
);
  logic [DATA_W-1:0] raw_sel;
  logic [DATA_W-1:0] fmt;

  generate
    if (SRC_COUNTER) begin : g_cnt_src
      logic [DATA_W-1:0] seq_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     seq_q <= '0;
        else if (load_i) seq_q <= seq_q + 1'b1;
      end
      assign raw_sel = seq_q;
    end else begin : g_pin_src
      assign raw_sel = raw_i;
    end
  endgenerate

  // offset binary to two's complement: invert the sign bit
  assign fmt = bipolar_i ? {~raw_sel[DATA_W-1], raw_sel[DATA_W-2:0]} : raw_sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     result_o <= '0;
    else if (load_i) result_o <= fmt;
  end
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
  parameter int DATA_W      = 16,
  parameter int WAKE_CYCLES = 1536,
  parameter int HOLD_PERIOD = 80,
  parameter int SYNC_STAGES = 2,
  parameter bit SRC_COUNTER = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              conv_ni,
  input  logic              bipolar_i,
  input  logic [DATA_W-1:0] raw_i,
  output logic              rdy_no,
  output logic [DATA_W-1:0] result_o
);
  // one idle cycle between back-to-back conversions
  localparam int CONV_LEN = HOLD_PERIOD - 1;

  logic req_low;
  logic mode_s;
  logic wake_done;
  logic conv_done;
  logic mode_q;

  adc_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .conv_ni   (conv_ni),
    .bipolar_i (bipolar_i),
    .req_low_o (req_low),
    .mode_o    (mode_s)
  );

  adc_wake_timer #(.WAKE_CYCLES(WAKE_CYCLES)) u_wake (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .done_o (wake_done)
  );

  adc_conv_ctrl #(.CONV_LEN(CONV_LEN)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wake_done_i (wake_done),
    .req_low_i   (req_low),
    .mode_i      (mode_s),
    .rdy_no      (rdy_no),
    .done_o      (conv_done),
    .mode_q_o    (mode_q)
  );

  adc_result_fmt #(.DATA_W(DATA_W), .SRC_COUNTER(SRC_COUNTER)) u_fmt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (conv_done),
    .bipolar_i (mode_q),
    .raw_i     (raw_i),
    .result_o  (result_o)
  );
endmodule

// File: rtl/adc_conv_seq_chk.sv
module adc_conv_seq_chk #(
  parameter int DATA_W      = 16,
  parameter int WAKE_CYCLES = 1536,
  parameter int HOLD_PERIOD = 80
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rdy_ni,
  input logic [DATA_W-1:0] result_i,
  input logic              req_low_i,
  input logic              mode_q_i
);
  localparam int CONV_LEN = HOLD_PERIOD - 1;

  int unsigned run_q;
  logic        awake_seen_q;

  // length of the current high stretch of ready
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q        <= 0;
      awake_seen_q <= 1'b0;
    end else if (rdy_ni) begin
      if (run_q < 32'hFFFF) run_q <= run_q + 1;
    end else begin
      run_q        <= 0;
      awake_seen_q <= 1'b1;
    end
  end

  a_r2_wake_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!awake_seen_q && $fell(rdy_ni)) |-> (run_q == WAKE_CYCLES));

  a_r3_conv_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (awake_seen_q && $fell(rdy_ni)) |-> (run_q == CONV_LEN));

  a_r7_start_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (awake_seen_q && !rdy_ni && req_low_i) |=> rdy_ni);

  a_r8_mode_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_ni && $past(rdy_ni)) |-> $stable(mode_q_i));

  a_r10_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(result_i) |-> $fell(rdy_ni));
endmodule

bind adc_conv_seq adc_conv_seq_chk #(
  .DATA_W      (DATA_W),
  .WAKE_CYCLES (WAKE_CYCLES),
  .HOLD_PERIOD (HOLD_PERIOD)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rdy_ni    (rdy_no),
  .result_i  (result_o),
  .req_low_i (req_low),
  .mode_q_i  (mode_q)
);

// File: tb/adc_conv_seq_tb_top.sv
module adc_conv_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        conv_drv = 1'b1;
  logic        tie = 1'b0;
  logic        bipolar = 1'b0;
  logic [15:0] raw = 16'hABCD;
  logic        rdy_n;
  logic [15:0] result;
  logic        conv_w;
  int          cyc = 0;
  int          total = 0;
  int          bad = 0;

  assign conv_w = tie ? rdy_n : conv_drv;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  adc_conv_seq dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .conv_ni   (conv_w),
    .bipolar_i (bipolar),
    .raw_i     (raw),
    .rdy_no    (rdy_n),
    .result_o  (result)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // edge number of the next ready fall, seen on falling edges
  task automatic next_fall(output int t);
    bit seen_hi = 1'b0;
    t = -1;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (rdy_n) seen_hi = 1'b1;
      else if (seen_hi) begin
        t = cyc;
        break;
      end
    end
  endtask

  task automatic stays_low(input string req, input int n);
    int hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (rdy_n) hi++;
    end
    chk(req, hi, 0);
  endtask

  task automatic t_reset_wake();
    int r, t;
    repeat (3) @(negedge clk);
    chk("R1 rdy in reset", int'(rdy_n), 1);
    chk("R1 result in reset", int'(result), 0);
    rst_n = 1'b1;
    r = cyc;
    repeat (100) @(negedge clk);
    conv_drv = 1'b0;
    repeat (6) @(negedge clk);
    conv_drv = 1'b1;
    next_fall(t);
    chk("R2 first ready edge", t, r + 1536);
    chk("R2 result after wake", int'(result), 0);
    stays_low("R2 wake request ignored", 20);
  endtask

  task automatic t_single();
    int c, t;
    @(negedge clk);
    c = cyc;
    raw = 16'h1234; bipolar = 1'b0; conv_drv = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R3 ready low before start", int'(rdy_n), 0);
    @(negedge clk);
    chk("R3 ready high at start", int'(rdy_n), 1);
    @(negedge clk);
    conv_drv = 1'b1;  // 4-clock pulse
    next_fall(t);
    chk("R6 single request latency", t, c + 82);
    chk("R3 high span", t - (c + 3), 79);
    chk("R7 four clock pulse result", int'(result), 16'h1234);
  endtask

  task automatic t_mode(input logic b_req, input logic b_after,
                        input logic [15:0] rv, input logic [15:0] exp);
    int c, t;
    @(negedge clk);
    c = cyc;
    raw = rv; bipolar = b_req; conv_drv = 1'b0;
    @(negedge clk);
    bipolar = b_after;
    repeat (3) @(negedge clk);
    conv_drv = 1'b1;
    next_fall(t);
    chk("R8 mode conversion time", t, c + 82);
    chk("R9 formatted result", int'(result), int'(exp));
  endtask

  task automatic t_busy_ignore();
    int c, t;
    logic [15:0] prev;
    @(negedge clk);
    c = cyc;
    prev = result;
    raw = 16'h0F0F; bipolar = 1'b0; conv_drv = 1'b0;
    repeat (4) @(negedge clk);
    conv_drv = 1'b1;
    repeat (26) @(negedge clk);
    chk("R10 result held while busy", int'(result), int'(prev));
    conv_drv = 1'b0;
    repeat (4) @(negedge clk);
    conv_drv = 1'b1;
    repeat (6) @(negedge clk);
    raw = 16'h3C3C;
    next_fall(t);
    chk("R7 busy request no restart", t, c + 82);
    chk("R9 raw sampled at ready fall", int'(result), 16'h3C3C);
    stays_low("R7 busy request not queued", 100);
  endtask

  task automatic t_hold();
    int t0, t1, t2, t3, t4;
    @(negedge clk);
    raw = 16'h4444; bipolar = 1'b0; conv_drv = 1'b0;
    next_fall(t0);
    next_fall(t1);
    next_fall(t2);
    next_fall(t3);
    conv_drv = 1'b1;
    chk("R4 held period 1", t1 - t0, 80);
    chk("R4 held period 2", t2 - t1, 80);
    chk("R4 held period 3", t3 - t2, 80);
    chk("R4 held result", int'(result), 16'h4444);
    next_fall(t4);
    chk("R4 committed conversion", t4, t3 + 80);
    stays_low("R4 stop after release", 100);
  endtask

  task automatic t_tied();
    int t0, t1, t2, t3;
    @(negedge clk);
    raw = 16'h0077; bipolar = 1'b1;
    tie = 1'b1;
    next_fall(t0);
    next_fall(t1);
    next_fall(t2);
    next_fall(t3);
    tie = 1'b0; conv_drv = 1'b1;
    chk("R5 tied period 1", t1 - t0, 82);
    chk("R5 tied period 2", t2 - t1, 82);
    chk("R5 tied period 3", t3 - t2, 82);
    chk("R9 tied bipolar result", int'(result), 16'h8077);
    stays_low("R5 no pending after untie", 100);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset_wake();
    t_single();
    t_mode(1'b1, 1'b0, 16'h0005, 16'h8005);
    t_mode(1'b0, 1'b1, 16'h8000, 16'h8000);
    t_mode(1'b1, 1'b1, 16'h0000, 16'h8000);
    t_mode(1'b1, 1'b1, 16'hFFFF, 16'h7FFF);
    t_mode(1'b0, 1'b0, 16'hFFFF, 16'hFFFF);
    t_busy_ignore();
    t_hold();
    t_tied();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule